// File: doc/BRIEF.md
# Automatic Level Control Gain Engine

This block steers the 6-bit gain code of an input amplifier so that a measured peak level settles at a programmable target. The code grid is 0.75 dB per step: code 0 is -12 dB, code 16 is 0 dB and code 63 is +35.25 dB. Each sample period the front end presents a tick, a peak level expressed as attenuation below full scale (in 0.75 dB units, larger means quieter) and the signed sample itself. A level louder than the target pulls the gain down at the attack rate. A level quieter than the target raises the gain at the decay rate, but only once a hold interval has elapsed with no loud sample.

Steps are timed in sample ticks. The attack and decay periods double with each code of their fields, and a limiter mode switches both to shorter base periods. The gain always stays inside a window set by two 3-bit fields in 6 dB steps. A noise gate stops the gain from rising while the input sits below a threshold. An optional zero-cross mode holds each step back until the sample changes sign. When the controller is off, the manual gain value passes straight through.

Top module: `alc_gain_engine`

## Requirements
- R1: With `cfg_en` low, `gain_out` equals `manual_gain` in the same cycle, the internal gain is reloaded from `manual_gain` on every clock, and `gate_active` is 0. After `cfg_en` rises, the gain starts from the last manual value.
- R2: The maximum field m clamps the gain at code 7+8m (m=0 is 7, m=7 is 63). The gain never steps above it.
- R3: The minimum field n sets a floor at code 8n. If the floor is above the ceiling, the ceiling wins and the window collapses to the ceiling code.
- R4: Target field k sets a threshold attenuation of 38-2k units. On a tick, `pk_att` below the threshold means "too loud", above it means "too quiet", and equal leaves every timer idle.
- R5: While too loud in normal mode, the gain drops one code on every P-th consecutive loud tick, where P = 2 << min(attack code, 10) ticks (bench parameters). A tick that is not loud clears the attack count.
- R6: While too quiet, past the hold and not gated, the gain rises one code every Q ticks, where Q = 3 << min(decay code, 10) ticks (bench parameters).
- R7: Hold lasts 0 ticks for code 0 and 4 << (code-1) ticks otherwise (bench parameters). It restarts on every loud tick, and decay counting begins only on the first tick after it has run out.
- R8: In limiter mode the attack base is 1 tick and the decay base is 2 ticks (bench parameters), still doubled per code.
- R9: With the gate enabled, a tick whose `pk_att` exceeds 52+8t (t = gate threshold field) never raises the gain, and it sets `gate_active` after that tick. The flag clears on the next tick that is not gated.
- R10: In zero-cross mode a requested step is kept pending. It is applied on the first tick whose sample sign bit differs from the sign bit of the previous tick's sample. A newer request replaces the pending one, and a gated rise is dropped.
- R11: The enabled gain changes by exactly one code per change and only in the cycle after a tick.
- R12: If the gain lies outside the window after a configuration change, it moves one code toward the window on every tick, whatever the level and zero-cross setting, and any pending step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Controller enable (0 = manual gain) |
| cfg_lim_mode | input | 1 | Limiter timing mode |
| cfg_target | input | 4 | Target level code |
| cfg_max | input | 3 | Ceiling code field |
| cfg_min | input | 3 | Floor code field |
| cfg_hold | input | 4 | Hold time code |
| cfg_atk | input | 4 | Attack period code |
| cfg_dcy | input | 4 | Decay period code |
| cfg_zc_en | input | 1 | Zero-cross gated update |
| cfg_ng_en | input | 1 | Noise gate enable |
| cfg_ng_thr | input | 3 | Noise gate threshold code |
| manual_gain | input | 6 | Gain used while disabled |
| tick | input | 1 | One-cycle sample strobe |
| pk_att | input | ATT_W (7) | Peak level below full scale, 0.75 dB units |
| sample | input | SMP_W (16) | Signed sample for sign tracking |
| gain_out | output | 6 | Gain code to the amplifier |
| gate_active | output | 1 | Noise gate currently holding gain |

## Verification
A wrong attack, hold or decay count does not show up as a wrong value at once. It shows up as a step that arrives one or more ticks early or late, so the bench compares the gain after every tick against a model, and the fault appears within one step period. A lost pending step or a stale sign bit in zero-cross mode appears only at the next sign change of the sample, and a wrong window decode appears only when a ramp reaches the clamp. For that reason the directed cases drive ramps into both clamp edges and force sign flips at chosen ticks. The random segments then mix every mode.

// File: rtl/alc_pkg.sv
// Shared types and decode helpers for the level control gain engine.
// Assumes a 6-bit gain code on a 0.75 dB grid (8 codes per 6 dB).
package alc_pkg;
    localparam int GAIN_W = 6;
    typedef logic [GAIN_W-1:0] gain_t;

    // Ceiling code: field 7 gives code 63, each lower field value 8 codes less.
    function automatic gain_t ceil_code(input logic [2:0] f);
        return gain_t'(7 + 8 * int'(f));
    endfunction

    // Floor code: field n gives code 8n.
    function automatic gain_t floor_code(input logic [2:0] f);
        return gain_t'(8 * int'(f));
    endfunction
endpackage

// File: rtl/alc_level_cmp.sv
// Classifies the peak level against the target and the noise gate.
// Assumes pk_att is attenuation below full scale in 0.75 dB units, ATT_W >= 7.
module alc_level_cmp #(
    parameter int ATT_W = 7
) (
    input  logic [ATT_W-1:0] pk_att,
    input  logic [3:0]       tgt_code,
    input  logic             ng_en,
    input  logic [2:0]       ng_code,
    output logic             too_loud,
    output logic             too_quiet,
    output logic             gated
);
    localparam int TGT_BASE  = 38;
    localparam int GATE_BASE = 52;

    logic [ATT_W-1:0] tgt_att;
    logic [ATT_W-1:0] gate_att;

    // Decode thresholds and compare the level against them.
    always_comb begin
        tgt_att   = ATT_W'(TGT_BASE - 2 * int'(tgt_code));
        gate_att  = ATT_W'(GATE_BASE + 8 * int'(ng_code));
        too_loud  = pk_att < tgt_att;
        too_quiet = pk_att > tgt_att;
        gated     = ng_en && (pk_att > gate_att);
    end
endmodule

// File: rtl/alc_step_timer.sv
// Hold, attack and decay tick counters; emits one-tick step requests.
// Assumes tick is a single-cycle strobe and all bases are at least 1.
module alc_step_timer #(
    parameter int HOLD_BASE    = 128,
    parameter int DCY_BASE     = 20,
    parameter int ATK_BASE     = 5,
    parameter int LIM_DCY_BASE = 4,
    parameter int LIM_ATK_BASE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       too_loud,
    input  logic       too_quiet,
    input  logic       gated,
    input  logic       lim_mode,
    input  logic [3:0] hold_code,
    input  logic [3:0] atk_code,
    input  logic [3:0] dcy_code,
    output logic       fire_up,
    output logic       fire_dn
);
    localparam int MAX_SHIFT = 10;
    localparam int MB1  = (HOLD_BASE > DCY_BASE) ? HOLD_BASE : DCY_BASE;
    localparam int MB2  = (ATK_BASE > LIM_DCY_BASE) ? ATK_BASE : LIM_DCY_BASE;
    localparam int MB3  = (MB1 > MB2) ? MB1 : MB2;
    localparam int MAXB = (MB3 > LIM_ATK_BASE) ? MB3 : LIM_ATK_BASE;
    localparam int CNT_W = $clog2(MAXB + 1) + 16;

    typedef logic [CNT_W-1:0] cnt_t;

    cnt_t atk_per, dcy_per, hold_per;
    cnt_t atk_cnt, dcy_cnt, hold_cnt;
    logic hold_done, dcy_go, atk_hit, dcy_hit;

    // Step period: base doubled per code, saturating at MAX_SHIFT.
    function automatic cnt_t period(input int base, input logic [3:0] code);
        int sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        return cnt_t'(base) << sh;
    endfunction

    // Select period bases by mode and derive request strobes.
    always_comb begin
        atk_per   = lim_mode ? period(LIM_ATK_BASE, atk_code) : period(ATK_BASE, atk_code);
        dcy_per   = lim_mode ? period(LIM_DCY_BASE, dcy_code) : period(DCY_BASE, dcy_code);
        hold_per  = (hold_code == 4'd0) ? '0 : (cnt_t'(HOLD_BASE) << (hold_code - 4'd1));
        hold_done = hold_cnt >= hold_per;
        dcy_go    = too_quiet && hold_done && !gated;
        atk_hit   = atk_cnt >= atk_per - cnt_t'(1);
        dcy_hit   = dcy_cnt >= dcy_per - cnt_t'(1);
        fire_dn   = run && tick && too_loud && atk_hit;
        fire_up   = run && tick && dcy_go && dcy_hit;
    end

    // Advance the three counters on each tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            atk_cnt  <= '0;
            dcy_cnt  <= '0;
            hold_cnt <= '0;
        end else if (tick) begin
            atk_cnt  <= too_loud ? (atk_hit ? '0 : atk_cnt + cnt_t'(1)) : '0;
            dcy_cnt  <= dcy_go ? (dcy_hit ? '0 : dcy_cnt + cnt_t'(1)) : '0;
            hold_cnt <= too_loud ? '0 : (hold_done ? hold_cnt : hold_cnt + cnt_t'(1));
        end
    end

    // R7: no rise request in the tick right after a loud tick restarted the hold
    p_hold_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && too_loud && hold_code != 4'd0) |=> !fire_up);
endmodule

// File: rtl/alc_gain_reg.sv
// Gain register with window correction, zero-cross pending step and manual load.
// Assumes step requests are single-tick strobes from the timer.
module alc_gain_reg
    import alc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cfg_en,
    input  gain_t manual_gain,
    input  logic  tick,
    input  logic  fire_up,
    input  logic  fire_dn,
    input  logic  gated,
    input  logic  zc_en,
    input  logic  sign_now,
    input  gain_t ceil_c,
    input  gain_t low_c,
    output gain_t gain_q
);
    logic pend_v, pend_up, prev_sgn;
    logic zc_edge, req_v, eff_v, eff_up, try_v, try_up;
    logic inc, dec, keep_pend, clr_pend;

    // Choose the step to apply this tick, if any.
    always_comb begin
        zc_edge   = sign_now != prev_sgn;
        req_v     = fire_up || fire_dn;
        eff_v     = req_v || pend_v;
        eff_up    = req_v ? fire_up : pend_up;
        try_v     = 1'b0;
        try_up    = 1'b0;
        inc       = 1'b0;
        dec       = 1'b0;
        keep_pend = 1'b0;
        clr_pend  = 1'b0;
        if (gain_q > ceil_c) begin
            dec = 1'b1; clr_pend = 1'b1;
        end else if (gain_q < low_c) begin
            inc = 1'b1; clr_pend = 1'b1;
        end else if (!zc_en) begin
            clr_pend = 1'b1; try_v = req_v; try_up = fire_up;
        end else if (zc_edge) begin
            clr_pend = 1'b1; try_v = eff_v; try_up = eff_up;
        end else if (req_v) begin
            keep_pend = 1'b1;
        end
        if (try_v && try_up && !gated && gain_q < ceil_c) inc = 1'b1;
        if (try_v && !try_up && gain_q > low_c) dec = 1'b1;
    end

    // Update gain, pending step and previous sign bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q   <= '0;
            pend_v   <= 1'b0;
            pend_up  <= 1'b0;
            prev_sgn <= 1'b0;
        end else begin
            if (tick) prev_sgn <= sign_now;
            if (!cfg_en) begin
                gain_q <= manual_gain;
                pend_v <= 1'b0;
            end else if (tick) begin
                if (inc) gain_q <= gain_q + gain_t'(1);
                else if (dec) gain_q <= gain_q - gain_t'(1);
                if (keep_pend) begin
                    pend_v  <= 1'b1;
                    pend_up <= fire_up;
                end else if (clr_pend) begin
                    pend_v <= 1'b0;
                end
            end
        end
    end

    // R11: enabled gain moves at most one code per clock
    p_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_en)) |->
        (gain_q == $past(gain_q) || gain_q == $past(gain_q) + gain_t'(1)
         || gain_q == $past(gain_q) - gain_t'(1)));
    // R11: no change without a tick while enabled
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_en) && !$past(tick)) |-> $stable(gain_q));
    // R1: disabled controller reloads the manual value
    p_manual_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> gain_q == $past(manual_gain));
    // R12: a gain above the ceiling drops on the next tick
    p_ceil_fix_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && tick && gain_q > ceil_c) |=> gain_q == $past(gain_q) - gain_t'(1));
endmodule

// File: rtl/alc_gain_engine.sv
// Top of the level control gain engine: compare, time and update the gain.
// Assumes one tick per sample; outputs follow the manual gain when disabled.
module alc_gain_engine
    import alc_pkg::*;
#(
    parameter int ATT_W        = 7,
    parameter int SMP_W        = 16,
    parameter int HOLD_BASE    = 128,
    parameter int DCY_BASE     = 20,
    parameter int ATK_BASE     = 5,
    parameter int LIM_DCY_BASE = 4,
    parameter int LIM_ATK_BASE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_lim_mode,
    input  logic [3:0]       cfg_target,
    input  logic [2:0]       cfg_max,
    input  logic [2:0]       cfg_min,
    input  logic [3:0]       cfg_hold,
    input  logic [3:0]       cfg_atk,
    input  logic [3:0]       cfg_dcy,
    input  logic             cfg_zc_en,
    input  logic             cfg_ng_en,
    input  logic [2:0]       cfg_ng_thr,
    input  logic [5:0]       manual_gain,
    input  logic             tick,
    input  logic [ATT_W-1:0] pk_att,
    input  logic [SMP_W-1:0] sample,
    output logic [5:0]       gain_out,
    output logic             gate_active
);
    logic  too_loud, too_quiet, gated, fire_up, fire_dn;
    gain_t ceil_c, flr_c, low_c, gain_q;
    logic  gate_q;

    // Decode the clamp window; the ceiling wins if the floor is above it.
    always_comb begin
        ceil_c = ceil_code(cfg_max);
        flr_c  = floor_code(cfg_min);
        low_c  = (flr_c > ceil_c) ? ceil_c : flr_c;
    end

    alc_level_cmp #(.ATT_W(ATT_W)) u_cmp (
        .pk_att    (pk_att),
        .tgt_code  (cfg_target),
        .ng_en     (cfg_ng_en),
        .ng_code   (cfg_ng_thr),
        .too_loud  (too_loud),
        .too_quiet (too_quiet),
        .gated     (gated)
    );

    alc_step_timer #(
        .HOLD_BASE    (HOLD_BASE),
        .DCY_BASE     (DCY_BASE),
        .ATK_BASE     (ATK_BASE),
        .LIM_DCY_BASE (LIM_DCY_BASE),
        .LIM_ATK_BASE (LIM_ATK_BASE)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cfg_en),
        .tick      (tick),
        .too_loud  (too_loud),
        .too_quiet (too_quiet),
        .gated     (gated),
        .lim_mode  (cfg_lim_mode),
        .hold_code (cfg_hold),
        .atk_code  (cfg_atk),
        .dcy_code  (cfg_dcy),
        .fire_up   (fire_up),
        .fire_dn   (fire_dn)
    );

    alc_gain_reg u_gain (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .manual_gain (manual_gain),
        .tick        (tick),
        .fire_up     (fire_up),
        .fire_dn     (fire_dn),
        .gated       (gated),
        .zc_en       (cfg_zc_en),
        .sign_now    (sample[SMP_W-1]),
        .ceil_c      (ceil_c),
        .low_c       (low_c),
        .gain_q      (gain_q)
    );

    // Latch the gate state once per tick; cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_en) gate_q <= 1'b0;
        else if (tick)         gate_q <= gated;
    end

    // Pass manual gain through when the controller is off.
    always_comb begin
        gain_out    = cfg_en ? gain_q : manual_gain;
        gate_active = gate_q;
    end

    // R9: a gated tick inside the window never raises the gain
    p_gate_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && tick && gated && gain_q >= low_c) |=> gain_q <= $past(gain_q));
    // R1: gate flag is low after a disabled cycle
    p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !gate_active);
endmodule

// File: tb/tb_alc_gain_engine.sv
module tb_alc_gain_engine;
    localparam int ATT_W = 7, SMP_W = 16;
    localparam int HB = 4, DB = 3, AB = 2, LDB = 2, LAB = 1;

    logic clk = 0, rst_n = 0;
    logic cfg_en = 0, cfg_lim_mode = 0, cfg_zc_en = 0, cfg_ng_en = 0;
    logic [3:0] cfg_target = 0, cfg_hold = 0, cfg_atk = 0, cfg_dcy = 0;
    logic [2:0] cfg_max = 7, cfg_min = 0, cfg_ng_thr = 0;
    logic [5:0] manual_gain = 16;
    logic tick = 0;
    logic [ATT_W-1:0] pk_att = 0;
    logic [SMP_W-1:0] sample = 16'd100;
    logic [5:0] gain_out;
    logic gate_active;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alc_gain_engine #(.ATT_W(ATT_W), .SMP_W(SMP_W), .HOLD_BASE(HB), .DCY_BASE(DB),
        .ATK_BASE(AB), .LIM_DCY_BASE(LDB), .LIM_ATK_BASE(LAB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_lim_mode(cfg_lim_mode),
        .cfg_target(cfg_target), .cfg_max(cfg_max), .cfg_min(cfg_min),
        .cfg_hold(cfg_hold), .cfg_atk(cfg_atk), .cfg_dcy(cfg_dcy),
        .cfg_zc_en(cfg_zc_en), .cfg_ng_en(cfg_ng_en), .cfg_ng_thr(cfg_ng_thr),
        .manual_gain(manual_gain), .tick(tick), .pk_att(pk_att), .sample(sample),
        .gain_out(gain_out), .gate_active(gate_active));

    // Reference model state, advanced at each rising edge from the bench inputs.
    int m_gain, m_atk, m_dcy, m_hold;
    bit m_pv, m_pu, m_prev, m_gate;

    function automatic int per(input int base, input int code);
        return base << ((code > 10) ? 10 : code);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gain = 0; m_atk = 0; m_dcy = 0; m_hold = 0;
            m_pv = 0; m_pu = 0; m_prev = 0; m_gate = 0;
        end else begin
            bit zce, hi, lo, gt, hd, fu, fd, tv, tu;
            int tgt, ceil_c, flr, low_c, ap, dp, hp;
            zce = sample[SMP_W-1] != m_prev;
            if (tick) m_prev = sample[SMP_W-1];
            if (!cfg_en) begin
                m_gain = manual_gain; m_pv = 0; m_atk = 0; m_dcy = 0; m_hold = 0; m_gate = 0;
            end else if (tick) begin
                tgt = 38 - 2 * cfg_target;
                hi = pk_att < tgt; lo = pk_att > tgt;
                gt = cfg_ng_en && (pk_att > 52 + 8 * cfg_ng_thr);
                ceil_c = 7 + 8 * cfg_max; flr = 8 * cfg_min;
                low_c = (flr > ceil_c) ? ceil_c : flr;
                ap = cfg_lim_mode ? per(LAB, cfg_atk) : per(AB, cfg_atk);
                dp = cfg_lim_mode ? per(LDB, cfg_dcy) : per(DB, cfg_dcy);
                hp = (cfg_hold == 0) ? 0 : HB << (cfg_hold - 1);
                hd = m_hold >= hp;
                fd = hi && (m_atk >= ap - 1);
                fu = lo && hd && !gt && (m_dcy >= dp - 1);
                m_atk = hi ? (fd ? 0 : m_atk + 1) : 0;
                m_dcy = (lo && hd && !gt) ? (fu ? 0 : m_dcy + 1) : 0;
                m_hold = hi ? 0 : (hd ? m_hold : m_hold + 1);
                m_gate = gt;
                tv = 0; tu = 0;
                if (m_gain > ceil_c) begin m_gain--; m_pv = 0; end
                else if (m_gain < low_c) begin m_gain++; m_pv = 0; end
                else begin
                    if (!cfg_zc_en) begin m_pv = 0; tv = fu || fd; tu = fu; end
                    else if (zce) begin
                        tv = fu || fd || m_pv; tu = (fu || fd) ? fu : m_pu; m_pv = 0;
                    end else if (fu || fd) begin m_pv = 1; m_pu = fu; end
                    if (tv && tu && !gt && m_gain < ceil_c) m_gain++;
                    else if (tv && !tu && m_gain > low_c) m_gain--;
                end
            end
        end
    end

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one tick with the given level and sample, then compare to the model.
    task automatic do_tick(input int pk, input int smp, input int idle);
        @(negedge clk);
        pk_att = ATT_W'(pk); sample = SMP_W'(smp); tick = 1;
        @(negedge clk);
        tick = 0;
        check(gain_out, cfg_en ? m_gain : manual_gain, "R11 model gain");
        check(gate_active, m_gate, "R9 model gate");
        repeat (idle) @(negedge clk);
    endtask

    task automatic ticks(input int n, input int pk, input int smp);
        for (int i = 0; i < n; i++) do_tick(pk, smp, 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset and disabled state
        check(gain_out, 16, "R1 disabled passthrough");
        check(gate_active, 0, "R1 gate low");
        manual_gain = 40; cfg_target = 5; @(negedge clk);
        cfg_en = 1; @(negedge clk);
        check(gain_out, 40, "R1 start from manual");
        // R5: attack per 2 ticks, pk 10 < threshold 28
        ticks(2, 10, 100); check(gain_out, 39, "R5 first attack step");
        ticks(4, 10, 100); check(gain_out, 37, "R5 attack per 2");
        cfg_atk = 2; ticks(8, 10, 100); check(gain_out, 36, "R5 attack code 2");
        // R6/R7: hold 4 ticks then decay per 3
        cfg_hold = 1; ticks(6, 40, 100); check(gain_out, 36, "R7 hold then count");
        ticks(1, 40, 100); check(gain_out, 37, "R6 first decay step");
        // R7: loud tick restarts hold
        ticks(1, 10, 100); ticks(6, 40, 100); check(gain_out, 37, "R7 before restart");
        ticks(1, 10, 100); ticks(6, 40, 100); check(gain_out, 37, "R7 hold restarted");
        ticks(1, 40, 100); check(gain_out, 38, "R7 decay after hold");
        // R8: limiter attack every tick
        cfg_lim_mode = 1; cfg_atk = 0; ticks(3, 10, 100); check(gain_out, 35, "R8 limiter attack");
        cfg_lim_mode = 0;
        // R12 and R2: ceiling at 7 corrects one per tick
        cfg_max = 0; ticks(5, 28, 100); check(gain_out, 30, "R12 one per tick");
        ticks(25, 28, 100); check(gain_out, 7, "R2 ceiling code 7");
        cfg_hold = 0; ticks(6, 40, 100); check(gain_out, 7, "R2 no rise past ceiling");
        // R3: floor above ceiling, ceiling wins
        cfg_min = 7; ticks(6, 10, 100); check(gain_out, 7, "R3 collapsed window");
        cfg_min = 0; cfg_max = 7;
        // R9: gated level (60 > 52) never raises
        cfg_ng_en = 1; ticks(10, 60, 100); check(gain_out, 7, "R9 gate holds gain");
        check(gate_active, 1, "R9 gate flag");
        ticks(3, 40, 100); check(gain_out, 8, "R9 decay resumes");
        check(gate_active, 0, "R9 flag cleared");
        cfg_ng_en = 0;
        // R10: zero-cross holds step until sign flips
        cfg_zc_en = 1; ticks(6, 10, 100); check(gain_out, 8, "R10 pending held");
        ticks(1, 10, -100); check(gain_out, 7, "R10 applied on sign change");
        cfg_zc_en = 0;
        // R4: equal level leaves gain unchanged
        ticks(8, 28, -5); check(gain_out, 7, "R4 level at target");
        // R1: disable passes manual
        @(negedge clk); cfg_en = 0; manual_gain = 21; #1;
        check(gain_out, 21, "R1 passthrough");
        @(negedge clk); check(gate_active, 0, "R1 gate off");
        // Random segments mixing every mode against the model
        for (int s = 0; s < 30; s++) begin
            @(negedge clk);
            cfg_en = ($urandom_range(0, 5) != 0);
            cfg_lim_mode = $urandom_range(0, 1);
            cfg_zc_en = $urandom_range(0, 1);
            cfg_ng_en = $urandom_range(0, 1);
            cfg_ng_thr = $urandom_range(0, 2);
            cfg_target = $urandom_range(0, 15);
            cfg_max = $urandom_range(0, 7);
            cfg_min = $urandom_range(0, 7);
            cfg_hold = $urandom_range(0, 3);
            cfg_atk = $urandom_range(0, 3);
            cfg_dcy = $urandom_range(0, 3);
            manual_gain = $urandom_range(0, 63);
            for (int t = 0; t < 60; t++) begin
                int pk;
                pk = 38 - 2 * int'(cfg_target) + $urandom_range(0, 50) - 20;
                if (pk < 0) pk = 0;
                do_tick(pk, $urandom_range(0, 65535), $urandom_range(0, 2));
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule